// File: doc/BRIEF.md
# Power Mode Controller

This block decides when the core's clocks run. Software issues a power-mode command that carries an 8-bit key. Key 0x01 puts the core into idle. In idle the CPU clock stops and the peripheral clocks keep running. Key 0x02 puts the core into powerdown, where both clock gates close and the oscillator is switched off. Powerdown is only accepted when the configuration enable bit is set. Any other key raises a one-cycle request for a device reset.

Wake-up depends on the mode. The external interrupt pin is synchronized first. It then counts as an event only after it has stayed high for a minimum number of cycles.

- **Idle:** only an enabled interrupt event wakes the core. The core is then told to service the interrupt.
- **Powerdown:** any interrupt event wakes the core. The wake status says whether to service the interrupt or resume after the command, according to the interrupt's enable bit.
- **Programming-voltage pin low:** this also ends powerdown. The clocks come back but the oscillator stays off, because the system is running from an external clock source.

Reset returns the block to normal mode from any state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, cpu_clk_en, per_clk_en and osc_en are 1, and key_reset_req and wake_valid are 0.
- R2: In normal mode, a command with key 0x01 moves to idle on the sampling edge: cpu_clk_en=0, per_clk_en=1, osc_en=1.
- R3: In normal mode, a command with key 0x02 while pd_allow=1 moves to powerdown on the sampling edge, and all three enables become 0.
- R4: A command with key 0x02 while pd_allow=0 leaves the mode and all enables unchanged.
- R5: In normal mode, a command with any key other than 0x01 or 0x02 gives key_reset_req=1 for exactly one cycle and leaves the mode unchanged.
- R6: A command that arrives while in idle or powerdown is ignored: the mode is unchanged and key_reset_req stays 0.
- R7: ext_irq_pin passes through SYNC_STAGES flops (default 2). A wake event needs the pin high for MIN_HIGH consecutive cycles (default 2). A pin that stays high gives only one event.
- R8: In idle, an event with ext_irq_en=1 returns to normal mode and pulses wake_valid with wake_service=1. With ext_irq_en=0 the event is ignored.
- R9: In powerdown, an event always returns to normal mode with osc_en=1. wake_valid pulses, and wake_service equals ext_irq_en.
- R10: In powerdown, prog_vpp low (after synchronization) returns to normal mode with cpu_clk_en=1, per_clk_en=1 and osc_en=0, and pulses wake_valid with wake_service=0.
- R11: After an R10 wake, osc_en stays 0 until reset or an interrupt wake from powerdown. Commands are accepted normally during this time.
- R12: If an interrupt event and prog_vpp low reach powerdown in the same cycle, the interrupt wins and osc_en becomes 1.
- R13: rst_n low returns the block from idle or powerdown to normal mode with all enables 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Power-mode command strobe |
| cmd_key | input | 8 | Key operand of the command |
| pd_allow | input | 1 | Configuration bit permitting powerdown |
| ext_irq_pin | input | 1 | External interrupt pin, asynchronous |
| ext_irq_en | input | 1 | Interrupt enable (1 = unmasked) |
| prog_vpp | input | 1 | Programming-voltage pin level, asynchronous |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| key_reset_req | output | 1 | Reset request for an illegal key |
| wake_valid | output | 1 | One-cycle wake indication |
| wake_service | output | 1 | With wake_valid: 1 = service interrupt, 0 = resume |

## Verification
The hardest case to reach from the ports is an interrupt event and a synchronized low programming-voltage level arriving at the powerdown state in the same cycle. The two pins pass through separate synchronizers, and the interrupt also has to pass the high-time qualifier. The bench raises the interrupt pin and then drops prog_vpp exactly one cycle later. That one-cycle offset makes up for the qualifier's extra cycle, so both conditions reach the state machine together.

The state that persists after a voltage-pin wake is the other hard case. The bench reaches it with a chain of steps: powerdown, a voltage-pin wake, an idle round trip, and then a second powerdown.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_state_t;

  typedef enum logic [1:0] {
    KC_NONE  = 2'd0,
    KC_IDLE  = 2'd1,
    KC_PDOWN = 2'd2,
    KC_BAD   = 2'd3
  } key_class_t;

  localparam logic [7:0] KEY_IDLE  = 8'h01;
  localparam logic [7:0] KEY_PDOWN = 8'h02;

  // Map a command key onto the action it requests.
  function automatic key_class_t classify_key(input logic [7:0] key, input logic pd_ok);
    if (key == KEY_IDLE)       return KC_IDLE;
    else if (key == KEY_PDOWN) return pd_ok ? KC_PDOWN : KC_NONE;
    else                       return KC_BAD;
  endfunction

  function automatic logic cpu_gate_open(input pm_state_t s);
    return s == PM_RUN;
  endfunction

  function automatic logic per_gate_open(input pm_state_t s);
    return s != PM_PDOWN;
  endfunction

  function automatic logic osc_running(input pm_state_t s, input logic ext_clk_mode);
    return (s != PM_PDOWN) && !ext_clk_mode;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwr_irq_qual.sv
module pwr_irq_qual #(
  parameter int MIN_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);

  localparam int CW = $clog2(MIN_HIGH + 1);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_cnt <= '0;
    else if (!lvl)                       hi_cnt <= '0;
    else if (hi_cnt != CW'(MIN_HIGH))    hi_cnt <= hi_cnt + 1'b1;
  end

  // Fires in the cycle the level completes its MIN_HIGH-th high sample.
  assign evt = lvl && (hi_cnt == CW'(MIN_HIGH - 1));

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  generate
    if (MIN_HIGH >= 2) begin : g_glitch_chk
      assert_short_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> !evt);
    end
  endgenerate

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_key,
  input  logic       pd_allow,
  input  logic       irq_evt,
  input  logic       irq_en,
  input  logic       vpp_low,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       key_reset_req,
  output logic       wake_valid,
  output logic       wake_service
);

  pm_state_t  st, st_n;
  key_class_t kc;
  logic       xclk, xclk_n;
  logic       krq_n, wv_n, ws_n;

  assign kc = classify_key(cmd_key, pd_allow);

  always_comb begin
    st_n   = st;
    xclk_n = xclk;
    krq_n  = 1'b0;
    wv_n   = 1'b0;
    ws_n   = 1'b0;
    case (st)
      PM_RUN: begin
        if (cmd_valid) begin
          case (kc)
            KC_IDLE:  st_n  = PM_IDLE;
            KC_PDOWN: st_n  = PM_PDOWN;
            KC_BAD:   krq_n = 1'b1;
            default:  ;
          endcase
        end
      end
      PM_IDLE: begin
        if (irq_evt && irq_en) begin
          st_n = PM_RUN;
          wv_n = 1'b1;
          ws_n = 1'b1;
        end
      end
      PM_PDOWN: begin
        if (irq_evt) begin
          st_n   = PM_RUN;
          xclk_n = 1'b0;
          wv_n   = 1'b1;
          ws_n   = irq_en;
        end else if (vpp_low) begin
          st_n   = PM_RUN;
          xclk_n = 1'b1;
          wv_n   = 1'b1;
        end
      end
      default: st_n = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= PM_RUN;
      xclk          <= 1'b0;
      key_reset_req <= 1'b0;
      wake_valid    <= 1'b0;
      wake_service  <= 1'b0;
    end else begin
      st            <= st_n;
      xclk          <= xclk_n;
      key_reset_req <= krq_n;
      wake_valid    <= wv_n;
      wake_service  <= ws_n;
    end
  end

  assign cpu_clk_en = cpu_gate_open(st);
  assign per_clk_en = per_gate_open(st);
  assign osc_en     = osc_running(st, xclk);

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && cmd_valid && cmd_key == 8'h01) |=> (!cpu_clk_en && per_clk_en));

  assert_pd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && cmd_valid && cmd_key == 8'h02 && pd_allow) |=> (!per_clk_en && !osc_en));

  assert_pd_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && cmd_valid && cmd_key == 8'h02 && !pd_allow) |=> (st == PM_RUN && !key_reset_req));

  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && cmd_valid && cmd_key != 8'h01 && cmd_key != 8'h02) |=> (key_reset_req && st == PM_RUN));

  assert_asleep_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PM_RUN && cmd_valid && !irq_evt && !vpp_low) |=> (!key_reset_req && st == $past(st)));

  assert_idle_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_IDLE && irq_evt && !irq_en) |=> (st == PM_IDLE && !wake_valid));

  assert_pd_irq_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_PDOWN && irq_evt) |=> (cpu_clk_en && osc_en && wake_valid && wake_service == $past(irq_en)));

  assert_vpp_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_PDOWN && vpp_low && !irq_evt) |=> (cpu_clk_en && per_clk_en && !osc_en && wake_valid && !wake_service));

  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_key,
  input  logic       pd_allow,
  input  logic       ext_irq_pin,
  input  logic       ext_irq_en,
  input  logic       prog_vpp,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       key_reset_req,
  output logic       wake_valid,
  output logic       wake_service
);

  logic irq_lvl;
  logic vpp_lvl;
  logic irq_evt;
  logic vpp_low;

  pwr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_irq_pin), .q(irq_lvl)
  );

  pwr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_vpp_sync (
    .clk(clk), .rst_n(rst_n), .d(prog_vpp), .q(vpp_lvl)
  );

  assign vpp_low = !vpp_lvl;

  pwr_irq_qual #(.MIN_HIGH(MIN_HIGH)) i_irq_qual (
    .clk(clk), .rst_n(rst_n), .lvl(irq_lvl), .evt(irq_evt)
  );

  pwr_mode_fsm i_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_key(cmd_key), .pd_allow(pd_allow),
    .irq_evt(irq_evt), .irq_en(ext_irq_en), .vpp_low(vpp_low),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .key_reset_req(key_reset_req), .wake_valid(wake_valid), .wake_service(wake_service)
  );

  assert_gate_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> (!cpu_clk_en && !osc_en));

  assert_simul_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && irq_evt && vpp_low) |=> osc_en);

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_key = 8'h00;
  logic       pd_allow = 1'b1;
  logic       ext_irq_pin = 1'b0;
  logic       ext_irq_en = 1'b1;
  logic       prog_vpp = 1'b1;
  logic       cpu_clk_en, per_clk_en, osc_en, key_reset_req, wake_valid, wake_service;

  int n_cmp = 0;
  int n_bad = 0;
  int wake_cnt = 0;
  logic last_svc = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_key(cmd_key),
    .pd_allow(pd_allow), .ext_irq_pin(ext_irq_pin), .ext_irq_en(ext_irq_en),
    .prog_vpp(prog_vpp), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .key_reset_req(key_reset_req), .wake_valid(wake_valid),
    .wake_service(wake_service)
  );

  always @(posedge clk) begin
    if (wake_valid) begin
      wake_cnt <= wake_cnt + 1;
      last_svc <= wake_service;
    end
  end

  // {key[7:0], pd_allow, exp cpu, exp per, exp osc, exp key_reset_req}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h02, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h03, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h1E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_gates(input string tag, input logic c, input logic p, input logic o);
    chk(tag, {29'd0, cpu_clk_en, per_clk_en, osc_en}, {29'd0, c, p, o});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    ext_irq_pin = 1'b0;
    prog_vpp = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] k, input logic pd);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_key = k;
    pd_allow = pd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic irq_pulse(input int high_cycles);
    @(negedge clk);
    ext_irq_pin = 1'b1;
    repeat (high_cycles) @(negedge clk);
    ext_irq_pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w0;
    do_reset();
    // R1 reset state
    chk_gates("R1 enables after reset", 1'b1, 1'b1, 1'b1);
    chk("R1 key_reset_req after reset", {31'd0, key_reset_req}, 32'd0);
    chk("R1 wake_valid after reset", {31'd0, wake_valid}, 32'd0);

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      do_reset();
      send_cmd(VEC[i][12:5], VEC[i][4]);
      chk_gates($sformatf("R2/R3/R4 vector %0d gates", i), VEC[i][3], VEC[i][2], VEC[i][1]);
      chk($sformatf("R5 vector %0d key_reset_req", i), {31'd0, key_reset_req}, {31'd0, VEC[i][0]});
      @(negedge clk);
      chk($sformatf("R5 vector %0d request is one cycle", i), {31'd0, key_reset_req}, 32'd0);
    end

    // R6 commands ignored while idle
    do_reset();
    send_cmd(8'h01, 1'b1);
    send_cmd(8'h02, 1'b1);
    chk_gates("R6 powerdown key in idle ignored", 1'b0, 1'b1, 1'b1);
    send_cmd(8'h55, 1'b1);
    chk("R6 bad key in idle no request", {31'd0, key_reset_req}, 32'd0);
    chk_gates("R6 bad key in idle mode kept", 1'b0, 1'b1, 1'b1);
    // R6 commands ignored while in powerdown
    do_reset();
    send_cmd(8'h02, 1'b1);
    send_cmd(8'h01, 1'b1);
    chk_gates("R6 idle key in powerdown ignored", 1'b0, 1'b0, 1'b0);

    // R7 a one-cycle glitch does not wake idle
    do_reset();
    ext_irq_en = 1'b1;
    send_cmd(8'h01, 1'b1);
    irq_pulse(1);
    chk_gates("R7 short pulse ignored", 1'b0, 1'b1, 1'b1);
    // R8 enabled event wakes idle with service
    w0 = wake_cnt;
    irq_pulse(3);
    chk_gates("R8 idle wake gates", 1'b1, 1'b1, 1'b1);
    chk("R8 idle wake count", wake_cnt - w0, 32'd1);
    chk("R8 idle wake service", {31'd0, last_svc}, 32'd1);
    // R8 masked event does not wake idle
    ext_irq_en = 1'b0;
    send_cmd(8'h01, 1'b1);
    irq_pulse(3);
    chk_gates("R8 masked event in idle ignored", 1'b0, 1'b1, 1'b1);
    ext_irq_en = 1'b1;
    // R7 pin held high gives one event only
    @(negedge clk);
    ext_irq_pin = 1'b1;
    repeat (8) @(negedge clk);
    chk_gates("R7 held pin wakes once", 1'b1, 1'b1, 1'b1);
    send_cmd(8'h01, 1'b1);
    repeat (8) @(negedge clk);
    chk_gates("R7 held pin gives no second event", 1'b0, 1'b1, 1'b1);
    ext_irq_pin = 1'b0;
    repeat (4) @(negedge clk);
    irq_pulse(2);
    chk_gates("R7 new rise after low wakes", 1'b1, 1'b1, 1'b1);

    // R9 powerdown wake by masked interrupt resumes
    do_reset();
    ext_irq_en = 1'b0;
    send_cmd(8'h02, 1'b1);
    w0 = wake_cnt;
    irq_pulse(3);
    chk_gates("R9 masked event wakes powerdown", 1'b1, 1'b1, 1'b1);
    chk("R9 masked wake count", wake_cnt - w0, 32'd1);
    chk("R9 masked wake service", {31'd0, last_svc}, 32'd0);
    // R9 enabled interrupt services
    ext_irq_en = 1'b1;
    send_cmd(8'h02, 1'b1);
    irq_pulse(3);
    chk_gates("R9 enabled event wakes powerdown", 1'b1, 1'b1, 1'b1);
    chk("R9 enabled wake service", {31'd0, last_svc}, 32'd1);

    // R10 prog_vpp low wake keeps oscillator off
    do_reset();
    send_cmd(8'h02, 1'b1);
    w0 = wake_cnt;
    @(negedge clk);
    prog_vpp = 1'b0;
    repeat (5) @(negedge clk);
    chk_gates("R10 vpp wake gates", 1'b1, 1'b1, 1'b0);
    chk("R10 vpp wake count", wake_cnt - w0, 32'd1);
    chk("R10 vpp wake service", {31'd0, last_svc}, 32'd0);
    prog_vpp = 1'b1;
    repeat (3) @(negedge clk);
    // R11 commands accepted, oscillator stays off across idle
    send_cmd(8'h01, 1'b1);
    chk_gates("R11 idle entered after vpp wake", 1'b0, 1'b1, 1'b0);
    irq_pulse(3);
    chk_gates("R11 osc still off after idle wake", 1'b1, 1'b1, 1'b0);
    send_cmd(8'h02, 1'b1);
    irq_pulse(3);
    chk_gates("R11 interrupt wake from powerdown restores osc", 1'b1, 1'b1, 1'b1);

    // R12 simultaneous interrupt and vpp in powerdown
    do_reset();
    send_cmd(8'h02, 1'b1);
    @(negedge clk);
    ext_irq_pin = 1'b1;
    @(negedge clk);
    prog_vpp = 1'b0;
    repeat (6) @(negedge clk);
    chk_gates("R12 interrupt wins over vpp", 1'b1, 1'b1, 1'b1);
    ext_irq_pin = 1'b0;
    prog_vpp = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset from powerdown and from idle
    do_reset();
    send_cmd(8'h02, 1'b1);
    do_reset();
    chk_gates("R13 reset leaves powerdown", 1'b1, 1'b1, 1'b1);
    send_cmd(8'h01, 1'b1);
    do_reset();
    chk_gates("R13 reset leaves idle", 1'b1, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule